// File: doc/BRIEF.md
# Lockable Countdown Watchdog

This block is a watchdog timer that software drives through one 32-bit control register. The register carries a 10-bit timeout, an enable, a lock that software can set once per power cycle, two sticky cause flags that record a watchdog-triggered reset, and a reload strobe. A prescaler turns a clock-enable input into a one-second tick. The counter runs down in whole seconds while the watchdog is enabled. When the count runs out, the block drives a reset pulse of fixed length.

The lock freezes the timeout, the enable and the lock itself until the next power-on reset. Reload stays usable while locked, so a locked, running watchdog can still be serviced but never stopped. There are two reset inputs. The power-on reset clears everything. The warm reset, which the pulse output may feed, keeps the lock and the cause flags, and it does not cut short a pulse already in progress.

Top module: `lockwdt_top`

## Requirements
- R1: After power-on reset, `rd_data` reads the default timeout field `INIT_TOV` (59) in bits [9:0] and 0 in every other bit (lock cleared), and `rst_out` is 0.
- R2: A write while unlocked loads bits [9:0] as the timeout field, bit 14 as enable and bit 12 as lock. Bit 31 and all bits other than 9:0, 12, 14, 24 and 25 always read 0.
- R3: Once bit 12 reads 1, no write can clear it, and writes cannot change bits [9:0] or bit 14. Only power-on reset clears it.
- R4: Writing 1 to bit 31 reloads the counter with (timeout field + 1) seconds, taking the field value that results from the same write. This works while locked.
- R5: Changing the timeout field without a reload or a fresh enable leaves the running countdown unchanged.
- R6: A one-second tick occurs on every `PRESCALE`-th cycle with `tick_en` high. The prescaler runs freely and restarts on warm reset. The counter decrements only on a tick while enabled.
- R7: Changing enable from 0 to 1 loads (field + 1) seconds. When a tick arrives with one second left, `rst_out` goes high from the next cycle for exactly `PULSE_LEN` cycles.
- R8: On expiry, an unlocked watchdog clears bit 14. A locked one keeps bit 14 set and reloads its counter.
- R9: Expiry sets bit 24 (or bit 25 when `SURVIVE` is 1). Writing 1 to a set status bit clears it. An expiry in the same cycle as a clear wins.
- R10: Warm reset keeps the lock and both status bits and lets a running pulse finish. When unlocked, it clears enable and restores the default field. When locked, enable and field are kept.
- R11: Clearing bit 14 while unlocked stops the countdown, so no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high, clears all state |
| warm_rst | input | 1 | Synchronous warm reset, active high, keeps lock and status |
| tick_en | input | 1 | Clock-enable pulses fed to the second prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| rst_out | output | 1 | Watchdog reset pulse |

## Verification
A write shows up on `rd_data` after the first rising edge that samples `wr_en`. A reload or start changes the count at that same edge. `rst_out` rises one edge after the tick that meets a count of one, and the cause flag and the enable change appear at that same edge. The bench keeps a behavioural model that steps at each rising edge from the same inputs. It compares every field of `rd_data` and `rst_out` at the following falling edge, so each result is read in the cycle it is due. Directed checks on service, disable, stall, lock and warm reset come on top of that comparison.

// File: rtl/lockwdt_pkg.sv
package lockwdt_pkg;

    localparam int TOV_W       = 10;
    localparam int REG_W       = 32;
    localparam int LOCK_BIT    = 12;
    localparam int EN_BIT      = 14;
    localparam int ST_PLAIN_BIT = 24;
    localparam int ST_SURV_BIT = 25;
    localparam int RELOAD_BIT  = 31;

    // Architectural register state
    typedef struct packed {
        logic             st_surv;
        logic             st_plain;
        logic             en;
        logic             lock;
        logic [TOV_W-1:0] tov;
    } wdt_ctrl_t;

    // Decoded write request
    typedef struct packed {
        logic             valid;
        logic [TOV_W-1:0] tov;
        logic             en;
        logic             lock;
        logic             reload;
        logic             clr_plain;
        logic             clr_surv;
    } wdt_wr_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input wdt_ctrl_t c);
        logic [REG_W-1:0] v;
        v                = '0;
        v[TOV_W-1:0]     = c.tov;
        v[LOCK_BIT]      = c.lock;
        v[EN_BIT]        = c.en;
        v[ST_PLAIN_BIT]  = c.st_plain;
        v[ST_SURV_BIT]   = c.st_surv;
        return v;
    endfunction

    function automatic wdt_wr_t decode_wr(input logic valid, input logic [REG_W-1:0] d);
        wdt_wr_t w;
        w.valid     = valid;
        w.tov       = d[TOV_W-1:0];
        w.en        = d[EN_BIT];
        w.lock      = d[LOCK_BIT];
        w.reload    = d[RELOAD_BIT];
        w.clr_plain = d[ST_PLAIN_BIT];
        w.clr_surv  = d[ST_SURV_BIT];
        return w;
    endfunction

endpackage

// File: rtl/lockwdt_prescaler.sv
module lockwdt_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic por_rst,
    input  logic clr,
    input  logic tick_en,
    output logic sec_tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign sec_tick = tick_en & ~clr;
        end else begin : g_count
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt;

            assign sec_tick = tick_en & ~clr & (cnt == LAST);

            always_ff @(posedge clk) begin
                if (por_rst || clr) begin
                    cnt <= '0;
                end else if (tick_en) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lockwdt_regs.sv
module lockwdt_regs
    import lockwdt_pkg::*;
#(
    parameter logic [TOV_W-1:0] INIT_TOV = 10'd59,
    parameter bit               SURVIVE  = 1'b0
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  wdt_wr_t          wr,
    input  logic             expire,
    output wdt_ctrl_t        ctrl,
    output logic [TOV_W-1:0] tov_nxt,
    output logic             start,
    output logic             reload
);
    localparam wdt_ctrl_t RST_CTRL = '{st_surv: 1'b0, st_plain: 1'b0, en: 1'b0,
                                       lock: 1'b0, tov: INIT_TOV};

    wdt_ctrl_t nxt_w;   // effect of write / warm reset
    wdt_ctrl_t nxt;     // after expiry overrides

    always_comb begin
        nxt_w  = ctrl;
        start  = 1'b0;
        reload = 1'b0;
        if (warm_rst) begin
            if (!ctrl.lock) begin
                nxt_w.en  = 1'b0;
                nxt_w.tov = INIT_TOV;
            end
        end else if (wr.valid) begin
            if (!ctrl.lock) begin
                nxt_w.tov  = wr.tov;
                nxt_w.en   = wr.en;
                nxt_w.lock = wr.lock;
            end
            if (wr.clr_plain) nxt_w.st_plain = 1'b0;
            if (wr.clr_surv)  nxt_w.st_surv  = 1'b0;
            reload = wr.reload;
            start  = wr.en & ~ctrl.en & ~ctrl.lock;
        end
        tov_nxt = nxt_w.tov;
    end

    always_comb begin
        nxt = nxt_w;
        if (expire) begin
            if (!ctrl.lock) nxt.en = 1'b0;
            if (SURVIVE) nxt.st_surv  = 1'b1;
            else         nxt.st_plain = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst) ctrl <= RST_CTRL;
        else         ctrl <= nxt;
    end
endmodule

// File: rtl/lockwdt_counter.sv
module lockwdt_counter #(
    parameter int               TOV_W    = 10,
    parameter logic [TOV_W-1:0] INIT_TOV = 10'd59
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  logic             en,
    input  logic             sec_tick,
    input  logic             load,
    input  logic [TOV_W-1:0] load_tov,
    output logic             expire
);
    localparam int CNT_W = TOV_W + 1;
    logic [CNT_W-1:0] secs_left;

    assign expire = en & sec_tick & ~warm_rst & (secs_left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (por_rst) begin
            secs_left <= {1'b0, INIT_TOV} + CNT_W'(1);
        end else if (load || expire) begin
            secs_left <= {1'b0, load_tov} + CNT_W'(1);
        end else if (en && sec_tick) begin
            secs_left <= secs_left - CNT_W'(1);
        end
    end
endmodule

// File: rtl/lockwdt_pulse.sv
module lockwdt_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic por_rst,
    input  logic fire,
    output logic rst_out
);
    localparam int W = $clog2(LEN + 1);
    logic [W-1:0] remain;

    assign rst_out = (remain != '0);

    always_ff @(posedge clk) begin
        if (por_rst)            remain <= '0;
        else if (fire)          remain <= W'(LEN);
        else if (remain != '0)  remain <= remain - W'(1);
    end
endmodule

// File: rtl/lockwdt_top.sv
module lockwdt_top
    import lockwdt_pkg::*;
#(
    parameter int PRESCALE  = 32768,
    parameter int PULSE_LEN = 16,
    parameter int INIT_TOV  = 59,
    parameter bit SURVIVE   = 1'b0
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        warm_rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        rst_out
);
    localparam logic [TOV_W-1:0] INIT_FIELD = TOV_W'(INIT_TOV);

    wdt_wr_t          wr;
    wdt_ctrl_t        ctrl;
    logic [TOV_W-1:0] tov_nxt;
    logic             start, reload, sec_tick, expire;
    logic             spare_unused;

    assign wr           = decode_wr(wr_en, wr_data);
    assign spare_unused = ^{wr_data[30:26], wr_data[23:15], wr_data[13], wr_data[11:10]};

    lockwdt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk      (clk),
        .por_rst  (por_rst),
        .clr      (warm_rst),
        .tick_en  (tick_en),
        .sec_tick (sec_tick)
    );

    lockwdt_regs #(.INIT_TOV(INIT_FIELD), .SURVIVE(SURVIVE)) u_regs (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .wr       (wr),
        .expire   (expire),
        .ctrl     (ctrl),
        .tov_nxt  (tov_nxt),
        .start    (start),
        .reload   (reload)
    );

    lockwdt_counter #(.TOV_W(TOV_W), .INIT_TOV(INIT_FIELD)) u_cnt (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .en       (ctrl.en),
        .sec_tick (sec_tick),
        .load     (warm_rst | reload | start),
        .load_tov (tov_nxt),
        .expire   (expire)
    );

    lockwdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .por_rst (por_rst),
        .fire    (expire),
        .rst_out (rst_out)
    );

    assign rd_data = pack_ctrl(ctrl);
endmodule

// File: rtl/lockwdt_checker.sv
module lockwdt_checker (
    input logic       clk,
    input logic       por_rst,
    input logic       wr_en,
    input logic       rst_out,
    input logic       lock_q,
    input logic       en_q,
    input logic [1:0] st_q,
    input logic [9:0] tov_q
);
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (por_rst)
        lock_q |=> lock_q); // R3
    AST_LOCK_TOV_FROZEN: assert property (@(posedge clk) disable iff (por_rst)
        lock_q |=> $stable(tov_q)); // R3
    AST_LOCK_EN_KEPT: assert property (@(posedge clk) disable iff (por_rst)
        (lock_q && en_q) |=> en_q); // R8
    AST_EXPIRY_CAUSE: assert property (@(posedge clk) disable iff (por_rst)
        $rose(rst_out) |-> (st_q != 2'b00)); // R9
    AST_EXPIRY_UNLOCKED_STOP: assert property (@(posedge clk) disable iff (por_rst)
        ($rose(rst_out) && !$past(lock_q)) |-> !en_q); // R8
    AST_EXPIRY_LOCKED_RUN: assert property (@(posedge clk) disable iff (por_rst)
        ($rose(rst_out) && $past(lock_q)) |-> en_q); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        ((st_q != 2'b00) && !wr_en) |=> (st_q != 2'b00)); // R10
endmodule

bind lockwdt_top lockwdt_checker u_chk (
    .clk     (clk),
    .por_rst (por_rst),
    .wr_en   (wr_en),
    .rst_out (rst_out),
    .lock_q  (rd_data[12]),
    .en_q    (rd_data[14]),
    .st_q    (rd_data[25:24]),
    .tov_q   (rd_data[9:0])
);

// File: tb/lockwdt_top_tb_top.sv
module lockwdt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_PRE   = 3;
    localparam int P_PULSE = 4;
    localparam int P_INIT  = 59;
    localparam bit P_SURV  = 1'b0;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        tick_en = 1'b0;
    logic        tick_hold = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int m_tov = P_INIT, m_cnt = P_INIT + 1, m_pre = 0, m_pulse = 0;
    bit m_en = 0, m_lock = 0, m_s24 = 0, m_s25 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockwdt_top #(.PRESCALE(P_PRE), .PULSE_LEN(P_PULSE), .INIT_TOV(P_INIT), .SURVIVE(P_SURV)) dut_i (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .tick_en(tick_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rst_out(rst_out)
    );

    always @(negedge clk) tick_en <= tick_hold ? 1'b0 : ~tick_en;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        bit sec, exp_now, ne, nl, start;
        int nt;
        started = 1'b1;
        cycles++;
        if (por_rst) begin
            m_tov = P_INIT; m_en = 0; m_lock = 0; m_s24 = 0; m_s25 = 0;
            m_cnt = P_INIT + 1; m_pre = 0; m_pulse = 0;
        end else begin
            sec = tick_en && (m_pre == P_PRE - 1) && !warm_rst;
            exp_now = !warm_rst && m_en && sec && (m_cnt == 1);
            m_pulse = exp_now ? P_PULSE : (m_pulse > 0 ? m_pulse - 1 : 0);
            if (warm_rst) begin
                m_pre = 0;
                if (!m_lock) begin m_en = 0; m_tov = P_INIT; end
                m_cnt = m_tov + 1;
            end else begin
                if (tick_en) m_pre = (m_pre == P_PRE - 1) ? 0 : m_pre + 1;
                nt = m_tov; ne = m_en; nl = m_lock; start = 0;
                if (wr_en && !m_lock) begin
                    nt = int'(wr_data[9:0]); ne = wr_data[14]; nl = wr_data[12];
                    start = ne && !m_en;
                end
                if (wr_en && wr_data[24]) m_s24 = 0;
                if (wr_en && wr_data[25]) m_s25 = 0;
                if (exp_now) begin
                    if (P_SURV) m_s25 = 1; else m_s24 = 1;
                    if (!m_lock) ne = 0;
                end
                if ((wr_en && wr_data[31]) || start || exp_now) m_cnt = nt + 1;
                else if (m_en && sec) m_cnt = m_cnt - 1;
                m_tov = nt; m_en = ne; m_lock = nl;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(int'(rd_data[9:0]) == m_tov, "R2 tov field", rd_data[9:0], m_tov);
            check(rd_data[14] == m_en, "R8 enable bit", rd_data[14], m_en);
            check(rd_data[12] == m_lock, "R3 lock bit", rd_data[12], m_lock);
            check(rd_data[25:24] == {m_s25, m_s24}, "R9 status bits", rd_data[25:24], {m_s25, m_s24});
            check({rd_data[31:26], rd_data[23:15], rd_data[13], rd_data[11:10]} == '0,
                  "R2 unused bits zero", rd_data, 0);
            check(rst_out == (m_pulse != 0), "R7 rst_out", rst_out, m_pulse != 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_rise(input int maxc, output int waited);
        waited = 0;
        while (!rst_out && waited < maxc) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int w, hi;
        bit seen;
        step(3);
        por_rst = 1'b0;
        step(1);
        check(rd_data == 32'd59, "R1 reset register", rd_data, 59);
        check(rst_out == 1'b0, "R1 reset rst_out", rst_out, 0);

        // R2: junk in unused bits, reload bit ignored in readback
        write(32'hC0F0_A803);
        check(rd_data == 32'h0000_0003, "R2 masked write", rd_data, 3);

        // R7: enable with 4 s timeout, run to expiry
        write(32'h0000_4003);
        wait_rise(200, w);
        check(rst_out == 1'b1, "R7 expiry reached", rst_out, 1);
        check(rd_data[14] == 1'b0, "R8 unlocked expiry disables", rd_data[14], 0);
        check(rd_data[24] == 1'b1, "R9 cause bit set", rd_data[24], 1);
        hi = 0;
        while (rst_out && hi < 50) begin step(1); hi++; end
        check(hi == P_PULSE, "R7 pulse length", hi, P_PULSE);

        // R9: write-1-to-clear
        write(32'h0100_0003);
        check(rd_data == 32'h0000_0003, "R9 status cleared", rd_data, 3);

        // R5: shrink the field mid-run without reload
        write(32'h0000_4009);
        step(12);
        write(32'h0000_4000);
        step(30);
        check(rst_out == 1'b0, "R5 field change does not restart", rst_out, 0);
        wait_rise(200, w);
        check(rst_out == 1'b1, "R5 original countdown expires", rst_out, 1);
        step(P_PULSE + 1);
        write(32'h0100_0000);

        // R11: disable before expiry
        write(32'h0000_4001);
        step(6);
        write(32'h0000_0001);
        seen = 0;
        repeat (100) begin step(1); if (rst_out) seen = 1; end
        check(seen == 1'b0, "R11 disabled no pulse", seen, 0);

        // R6: no tick_en, no progress
        tick_hold = 1'b1;
        write(32'h0000_4000);
        seen = 0;
        repeat (60) begin step(1); if (rst_out) seen = 1; end
        check(seen == 1'b0, "R6 stalled without tick_en", seen, 0);
        tick_hold = 1'b0;
        wait_rise(50, w);
        check(rst_out == 1'b1, "R6 counts once ticks resume", rst_out, 1);
        step(P_PULSE + 1);
        write(32'h0100_0000);

        // R3/R4: lock, then attempt changes and service
        write(32'h0000_5002);
        write(32'h0000_0000);
        check(rd_data[14:0] == 15'h5002, "R3 locked write ignored", rd_data[14:0], 32'h5002);
        seen = 0;
        repeat (10) begin
            write(32'h8000_0000);
            repeat (11) begin step(1); if (rst_out) seen = 1; end
        end
        check(seen == 1'b0, "R4 reload while locked keeps alive", seen, 0);
        wait_rise(200, w);
        check(rst_out == 1'b1, "R4 expiry after service stops", rst_out, 1);
        check(rd_data[14] == 1'b1, "R8 locked stays enabled", rd_data[14], 1);

        // R10: warm reset during the pulse
        warm_rst = 1'b1;
        step(2);
        warm_rst = 1'b0;
        check(rd_data == 32'h0100_5002, "R10 warm keeps lock status", rd_data, 32'h0100_5002);
        step(P_PULSE + 2);
        write(32'h0100_0000);
        check(rd_data[24] == 1'b0, "R9 clear while locked", rd_data[24], 0);

        // R1: power-on reset releases the lock
        por_rst = 1'b1;
        step(2);
        por_rst = 1'b0;
        step(1);
        check(rd_data == 32'd59, "R1 por clears lock", rd_data, 59);
        finish_run();
    end

    initial begin
        wait (cycles > 150000);
        check(1'b0, "watchdog timeout", cycles, 0);
        finish_run();
    end
endmodule